// File: doc/BRIEF.md
# High-Rate Sample Splitter onto I2S Lanes

This block takes one fast stream of 24-bit converter samples and deals them out, in a fixed round-robin order, onto several I2S lanes that each run at an ordinary 192 kHz frame rate. A capture host records every lane as if it were a set of standard stereo channels. It then interleaves the slots again in the same order to rebuild the original 384 kHz, 768 kHz or 1536 kHz stream. The block derives the bit clock and the word-select signal from its own master clock and drives them to all lanes. Every lane therefore switches frames on the same edge.

Samples enter through a valid/ready stream port. The block collects one frame's worth of samples, called a group, in a fill buffer. At the next frame boundary it copies the whole group into the output registers of every lane at once. Once a group is complete, the port applies back-pressure by holding `in_ready` low until the next boundary. `in_ready` is also low for the single boundary cycle itself. A transfer happens on any rising `clk` edge where `in_valid` and `in_ready` are both high. Sources that cannot be paused are caught by a sticky overflow flag. The flag sets when such a source offers a sample while the group is already complete.

Three packing modes exist. In stereo 2x mode, each channel at 384 kHz occupies half of the lanes. In stereo 4x mode, each channel at 768 kHz occupies all lanes. In mono 8x mode, a single 1536 kHz channel occupies every slot. In the stereo modes the source presents samples as left, right, left, right, and so on.

Top module: `hirate_i2s_splitter`

## Requirements
- R1: While `rst_n` is low, `in_ready` is 1 and `overflow`, `i2s_bclk`, `i2s_ws` and every `i2s_sd` bit are 0. The first frame after reset carries zero in every slot.
- R2: `i2s_bclk` has a period of 2*HALF_DIV clock cycles. A frame lasts 64 bit clocks. `i2s_ws` is 0 for the first 32 bits of the frame (left slot) and 1 for the last 32 bits (right slot), and it changes only together with a falling bit-clock edge.
- R3: Each slot is 32 bits long. Bit position 0 of the slot is 0. Positions 1 to 24 carry the sample MSB first, so the MSB is captured on the second rising bit-clock edge after the word-select change. Positions 25 to 31 are 0. `i2s_sd` changes only together with a falling bit-clock edge.
- R4: With `mode_sel` = 00 (stereo 2x), a group holds LANES samples. Sample k of a group goes to lane k/2: to the left slot when k is even and to the right slot when k is odd. Lanes LANES/2 and above carry zero.
- R5: With `mode_sel` = 01 (stereo 4x), 10 (mono 8x) or 11 (treated as 10), a group holds 2*LANES samples, placed in the same lane/slot order across all lanes.
- R6: A group completed during frame F appears on all lanes during frame F+1. After the last sample of a group is accepted, `in_ready` stays low until the next frame boundary. A frame that follows a boundary without a complete group carries zero in every slot.
- R7: A group that is incomplete at a frame boundary is discarded. The following frame carries zeros, and filling restarts at slot 0 with `in_ready` high.
- R8: `mode_sel` is sampled only at a frame boundary. Until that boundary, the group size and the layout of the group being filled stay those of the previous mode.
- R9: `overflow` rises one clock after a cycle in which `in_valid` is high while the group is complete. No sample is taken in that cycle, and the flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock; all lane timing derives from it |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 2 | Packing mode request, applied at the next frame boundary |
| in_valid | input | 1 | Source offers a sample |
| in_ready | output | 1 | Block can accept a sample this cycle |
| in_data | input | SAMPLE_W (24) | Sample value, two's complement |
| i2s_bclk | output | 1 | Shared bit clock |
| i2s_ws | output | 1 | Shared word select, 0 = left slot |
| i2s_sd | output | LANES (4) | Serial data, one bit per lane |
| overflow | output | 1 | Sticky flag: sample offered while the group was complete |

## Verification
Every lane result is due one frame after its group closes. A group pushed early in frame F is compared against the slots the bench's own I2S receiver captured for frame F+1. The bench waits on its receiver's frame counter rather than on a fixed cycle count. The receiver samples data on the rising bit-clock edge, half a bit clock after the falling edge that changes it. The flow-control results are checked at the next falling clock edge after the stimulus. These are `in_ready` going low after the last sample of a group, and `in_ready` staying low after a mid-frame mode request. `overflow` is checked one clock after the offending offer and again a frame later.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    MODE_ST2X   = 2'b00,
    MODE_ST4X   = 2'b01,
    MODE_MONO8X = 2'b10,
    MODE_MONO_B = 2'b11
  } sp_mode_e;

  // Samples per group: the 2x stereo mode fills half of the lanes.
  function automatic int unsigned slots_for(sp_mode_e m, int unsigned lanes);
    return (m == MODE_ST2X) ? lanes : 2 * lanes;
  endfunction
endpackage

// File: rtl/sp_bitclk.sv
module sp_bitclk #(
  parameter int unsigned HALF_DIV = 1,
  parameter int unsigned IDX_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             bclk,
  output logic             ws,
  output logic [IDX_W-1:0] bit_idx,
  output logic             frame_go
);
  localparam int unsigned DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0] div_cnt;
  logic             tick;

  assign tick     = (div_cnt == DIV_W'(HALF_DIV - 1));
  assign frame_go = tick && bclk && (bit_idx == '1);
  assign ws       = bit_idx[IDX_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      bclk    <= 1'b0;
      bit_idx <= '0;
    end else if (tick) begin
      div_cnt <= '0;
      bclk    <= ~bclk;
      if (bclk) bit_idx <= bit_idx + 1'b1;  // advance on the falling edge
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sp_slotbuf.sv
module sp_slotbuf #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned NSLOT    = 8,
  parameter int unsigned CNT_W    = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           frame_go,
  input  logic [CNT_W-1:0]               need,
  input  logic                           in_valid,
  input  logic [SAMPLE_W-1:0]            in_data,
  output logic                           in_ready,
  output logic                           full,
  output logic [NSLOT-1:0][SAMPLE_W-1:0] shadow
);
  logic [NSLOT-1:0][SAMPLE_W-1:0] fill;
  logic [CNT_W-1:0]               wr_idx;

  assign full     = (wr_idx >= need);
  assign in_ready = !full && !frame_go;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_idx <= '0;
      fill   <= '0;
      shadow <= '0;
    end else if (frame_go) begin
      wr_idx <= '0;
      for (int s = 0; s < NSLOT; s++)
        shadow[s] <= (full && (CNT_W'(s) < need)) ? fill[s] : '0;
    end else if (in_valid && in_ready) begin
      for (int s = 0; s < NSLOT; s++)
        if (wr_idx == CNT_W'(s)) fill[s] <= in_data;
      wr_idx <= wr_idx + 1'b1;
    end
  end
endmodule

// File: rtl/sp_lane_ser.sv
module sp_lane_ser #(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned IDX_W    = 6
) (
  input  logic [IDX_W-1:0]    bit_idx,
  input  logic [SAMPLE_W-1:0] left,
  input  logic [SAMPLE_W-1:0] right,
  output logic                sd
);
  localparam int unsigned PW = IDX_W - 1;

  logic [PW-1:0]       pos;
  logic [SAMPLE_W-1:0] word;

  assign pos  = bit_idx[PW-1:0];
  assign word = bit_idx[IDX_W-1] ? right : left;

  // Position p in 1..SAMPLE_W carries word bit SAMPLE_W-p; all else is zero.
  always_comb begin
    sd = 1'b0;
    for (int k = 0; k < SAMPLE_W; k++)
      if (pos == PW'(SAMPLE_W - k)) sd = word[k];
  end
endmodule

// File: rtl/hirate_i2s_splitter.sv
module hirate_i2s_splitter
  import sp_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned SLOT_W   = 32,
  parameter int unsigned LANES    = 4,
  parameter int unsigned HALF_DIV = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          mode_sel,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                i2s_bclk,
  output logic                i2s_ws,
  output logic [LANES-1:0]    i2s_sd,
  output logic                overflow
);
  localparam int unsigned NSLOT = 2 * LANES;
  localparam int unsigned CNT_W = $clog2(NSLOT + 1);
  localparam int unsigned IDX_W = $clog2(2 * SLOT_W);

  logic                           frame_go;
  logic [IDX_W-1:0]               bit_idx;
  sp_mode_e                       act_mode;
  logic [CNT_W-1:0]               need;
  logic                           grp_full;
  logic [NSLOT-1:0][SAMPLE_W-1:0] shadow;

  sp_bitclk #(.HALF_DIV(HALF_DIV), .IDX_W(IDX_W)) u_bitclk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bclk     (i2s_bclk),
    .ws       (i2s_ws),
    .bit_idx  (bit_idx),
    .frame_go (frame_go)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        act_mode <= MODE_ST2X;
    else if (frame_go) act_mode <= sp_mode_e'(mode_sel);
  end

  assign need = CNT_W'(slots_for(act_mode, LANES));

  sp_slotbuf #(.SAMPLE_W(SAMPLE_W), .NSLOT(NSLOT), .CNT_W(CNT_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .frame_go (frame_go),
    .need     (need),
    .in_valid (in_valid),
    .in_data  (in_data),
    .in_ready (in_ready),
    .full     (grp_full),
    .shadow   (shadow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                   overflow <= 1'b0;
    else if (in_valid && grp_full) overflow <= 1'b1;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sp_lane_ser #(.SAMPLE_W(SAMPLE_W), .IDX_W(IDX_W)) u_ser (
      .bit_idx (bit_idx),
      .left    (shadow[2*l]),
      .right   (shadow[2*l+1]),
      .sd      (i2s_sd[l])
    );
  end
endmodule

// File: rtl/hirate_i2s_splitter_chk.sv
module hirate_i2s_splitter_chk #(
  parameter int unsigned LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             i2s_bclk,
  input logic             i2s_ws,
  input logic [LANES-1:0] i2s_sd,
  input logic             in_valid,
  input logic             in_ready,
  input logic             overflow
);
  AST_WS_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (i2s_ws != $past(i2s_ws)) |-> (!i2s_bclk && $past(i2s_bclk))); // R2
  AST_SD_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (i2s_sd != $past(i2s_sd)) |-> (!i2s_bclk && $past(i2s_bclk))); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(overflow) |-> overflow); // R9
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(in_valid && !in_ready)); // R9
endmodule

bind hirate_i2s_splitter hirate_i2s_splitter_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .i2s_bclk (i2s_bclk),
  .i2s_ws   (i2s_ws),
  .i2s_sd   (i2s_sd),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .overflow (overflow)
);

// File: tb/hirate_i2s_splitter_test.sv
module hirate_i2s_splitter_test;
  localparam int LANES = 4;
  localparam int NS    = 2 * LANES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [23:0] in_data = '0;
  logic i2s_bclk, i2s_ws, overflow;
  logic [LANES-1:0] i2s_sd;

  always #2 clk = ~clk;  // 250 MHz

  hirate_i2s_splitter uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .i2s_bclk(i2s_bclk),
    .i2s_ws(i2s_ws), .i2s_sd(i2s_sd), .overflow(overflow)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  always @(posedge clk) cyc++;

  // Bench-side I2S receiver
  int rx_bit = 0, rx_frames = 0, start_cyc = 0;
  logic [23:0] cur [NS];
  logic [23:0] cap [64][NS];
  bit ws_bad = 0, zero_bad = 0;
  bit wsb_f [64];
  bit zb_f  [64];
  int len_f [64];

  always @(posedge i2s_bclk or negedge rst_n) begin : rx
    int pos, p, side;
    if (!rst_n) begin
      rx_bit = 0; rx_frames = 0; ws_bad = 0; zero_bad = 0;
    end else begin
      pos = rx_bit % 64; p = pos % 32; side = (pos >= 32) ? 1 : 0;
      if (pos == 0) start_cyc = cyc;
      if (i2s_ws !== side[0]) ws_bad = 1;
      for (int l = 0; l < LANES; l++) begin
        if (p >= 1 && p <= 24) cur[2*l+side][24-p] = i2s_sd[l];
        else if (i2s_sd[l] !== 1'b0) zero_bad = 1;
      end
      if (pos == 63 && rx_frames < 64) begin
        for (int s = 0; s < NS; s++) cap[rx_frames][s] = cur[s];
        wsb_f[rx_frames] = ws_bad; zb_f[rx_frames] = zero_bad;
        len_f[rx_frames] = cyc - start_cyc;
        ws_bad = 0; zero_bad = 0;
        rx_frames++;
      end
      rx_bit++;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [23:0] gval(input int k);
    logic [31:0] t;
    t = k * 32'h0009E3B5 + 32'h000A51C3;
    return t[23:0] | 24'h1;
  endfunction

  task automatic push(input logic [23:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send(input int n, input int base);
    for (int i = 0; i < n; i++) push(gval(base + i));
  endtask

  task automatic sync_frame();
    int f;
    f = rx_frames;
    wait (rx_frames != f);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frame(input int idx, input int n, input int base, input string req);
    wait (rx_frames > idx);
    for (int s = 0; s < NS; s++) begin
      logic [23:0] e;
      e = (s < n) ? gval(base + s) : 24'h0;
      chk(cap[idx][s] === e, req, $sformatf("frame %0d slot %0d", idx, s), 32'(cap[idx][s]), 32'(e));
    end
    chk(!wsb_f[idx], "R2", $sformatf("ws alignment frame %0d", idx), 32'(wsb_f[idx]), 0);
    chk(len_f[idx] == 126, "R2", $sformatf("63 bit clocks frame %0d", idx), len_f[idx], 126);
    chk(!zb_f[idx], "R3", $sformatf("padding bits zero frame %0d", idx), 32'(zb_f[idx]), 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R6 watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    int c, base;
    base = 0;
    repeat (5) @(negedge clk);
    chk(in_ready === 1'b1, "R1", "ready in reset", 32'(in_ready), 1);
    chk(overflow === 1'b0, "R1", "overflow in reset", 32'(overflow), 0);
    chk({i2s_bclk, i2s_ws, i2s_sd} === '0, "R1", "i2s pins in reset",
        32'({i2s_bclk, i2s_ws, i2s_sd}), 0);
    rst_n = 1'b1;
    check_frame(0, 0, 0, "R1");

    // R4: stereo 2x, two consecutive groups
    for (int g = 0; g < 2; g++) begin
      sync_frame(); c = rx_frames;
      send(LANES, base);
      chk(in_ready === 1'b0, "R6", "ready low after full group", 32'(in_ready), 0);
      check_frame(c + 1, LANES, base, "R4");
      base += LANES;
    end
    check_frame(rx_frames, 0, 0, "R6");  // frame with no group is silent

    // R8: mode request mid-frame while a 2x group is complete
    sync_frame(); c = rx_frames;
    send(LANES, base);
    mode_sel = 2'b01;
    repeat (8) @(negedge clk);
    chk(in_ready === 1'b0, "R8", "mode not applied mid-frame", 32'(in_ready), 0);
    check_frame(c + 1, LANES, base, "R8");
    base += LANES;

    // R5: stereo 4x, mono 8x and code 11
    for (int m = 1; m < 4; m++) begin
      mode_sel = 2'(m);
      sync_frame(); sync_frame(); c = rx_frames;
      send(NS, base);
      chk(in_ready === 1'b0, "R5", $sformatf("ready low after %0d samples", NS), 32'(in_ready), 0);
      check_frame(c + 1, NS, base, "R5");
      base += NS;
    end

    // R7: partial group dropped at boundary
    sync_frame(); c = rx_frames;
    send(2, base);
    base += 2;
    sync_frame();
    chk(in_ready === 1'b1, "R7", "ready after flush", 32'(in_ready), 1);
    send(NS, base);
    check_frame(c + 1, 0, 0, "R7");
    check_frame(c + 2, NS, base, "R7");
    base += NS;

    // R9: sample offered while group complete
    sync_frame(); c = rx_frames;
    send(NS, base);
    chk(overflow === 1'b0, "R9", "no overflow under flow control", 32'(overflow), 0);
    in_valid = 1'b1; in_data = 24'hFFFFFF;
    @(negedge clk);
    in_valid = 1'b0;
    chk(overflow === 1'b1, "R9", "overflow raised", 32'(overflow), 1);
    check_frame(c + 1, NS, base, "R9");
    chk(overflow === 1'b1, "R9", "overflow sticky", 32'(overflow), 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule